// File: doc/BRIEF.md
# Multiply/ALU execution unit

This block is the arithmetic datapath of a small 16-bit fixed-point signal processor. It holds two 16-bit operand registers (x and y), a 32-bit signed product register p and two 36-bit accumulators with four guard bits each. Every instruction it accepts carries two independent parts. The function part chooses a multiply, an accumulate or subtract of p or y, a plain load, a bitwise operation or a flags-only compare/test. The transfer part moves operands between the registers and a simple data memory port, which has an X space and a Y space. The two parts run together and commit together.

The transfer part also sets the instruction's length. Stores take two cycles. A dual read of both spaces takes two cycles outside the instruction cache and one inside it. A same-bank clash between the two reads adds one cycle. Programmed wait-states are added to any transfer that touches memory. The unit raises `busy` for every extra cycle and ignores new instructions while it is busy. It commits every register update at the final clock edge, marked by `done`, and all computation uses the register values from before that edge. A configuration bit decides whether loading an accumulator's upper half keeps or clears its lower half.

Top module: `mac_alu_unit`

## Requirements
- R1: Function code 1 (and the combined codes 13, 14, 15) sets p to the signed product of the x and y values held before the instruction, even when the same instruction's transfer reloads x or y.
- R2: Function codes 2 (aD = p), 3 (aD = aS + p), 4 (aD = aS - p) and the combined codes 13/14/15 (the same three, plus p = x*y) use p sign-extended to 36 bits, and take p's value from before any multiply in the same instruction. `dst_sel` picks aD and `src_sel` picks aS (0 = a0, 1 = a1).
- R3: Function codes 5 (aD = y), 6 (aD = aS + y) and 7 (aD = aS - y) use the operand formed from y sign-extended into bits 35:16 with bits 15:0 zero.
- R4: Function codes 8, 9 and 10 write aS AND, OR and XOR that y operand (as in R3) into aD, across all 36 bits.
- R5: Function codes 2 to 15 other than 1 update the flags from the 36-bit result r: N = r[35], Z = (r == 0), V = 1 when r[35:31] is neither all ones nor all zeros, and C = the carry out of bit 35 of the add (for a subtract, the carry of aS + ~op + 1, which is 1 when no borrow occurs). C is 0 for loads and bitwise operations. Codes 11 (aS - y) and 12 (aS & y) update the flags only and write no accumulator. Codes 0 and 1 leave the flags unchanged.
- R6: Instruction length: transfer codes 0, 2, 3, 4 and 7 take 1 cycle. Codes 5 and 6 (stores) take 2 cycles. Code 1 (dual read) takes 1 cycle with `in_cache` = 1 and 2 cycles otherwise, plus 1 when `bank_hit` = 1. `wait_states` is added for codes 1 to 6.
- R7: `busy` is high in cycles 2 to N of an N-cycle instruction and low otherwise. `done` is high only in the final cycle. `issue` is ignored while `busy` is high.
- R8: Transfer code 4 with `low_sel` = 0 loads aT bits 35:16 with `ydata` sign-extended (`acc_t_sel` picks aT). Bits 15:0 become 0 when the keep bit is 0 and keep their value when it is 1. The keep bit is written from `cfg_keep_low` when `cfg_we` = 1 and resets to 0.
- R9: With `low_sel` = 1, transfer code 4 writes only aT bits 15:0. Transfer codes 6 and 7 use aT bits 15:0 instead of bits 31:16.
- R10: `mem_we` is high only in an instruction's final cycle, and only for transfer 5 (data = y) or 6 (data = aT half per R9).
- R11: Function code 0 with transfer code 0 (nop) takes one cycle and changes no register or flag.
- R12: Transfer 1 loads y from `ydata` and x from `xdata`, 2 loads y, 3 loads x, and 7 copies an aT half into y. The function reads the registers' old values. When a transfer and a function write the same accumulator, the transfer's value (built from the old accumulator) is kept.
- R13: After reset, all registers, the flags, `busy` and the keep bit are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction present (taken when not busy) |
| func | input | 4 | Function code |
| xfer | input | 3 | Transfer code |
| dst_sel | input | 1 | Destination accumulator of the function |
| src_sel | input | 1 | Source accumulator of the function |
| acc_t_sel | input | 1 | Accumulator used by the transfer |
| low_sel | input | 1 | Transfer uses the low half of the accumulator |
| in_cache | input | 1 | Instruction is executing from the cache |
| bank_hit | input | 1 | X and Y reads hit the same bank |
| wait_states | input | WSW | External wait-states for this access |
| cfg_we | input | 1 | Write the keep bit |
| cfg_keep_low | input | 1 | Keep-bit value |
| xdata | input | DW | X-space read data (valid in the final cycle) |
| ydata | input | DW | Y-space read data (valid in the final cycle) |
| mem_we | output | 1 | Store strobe |
| mem_wdata | output | DW | Store data |
| busy | output | 1 | Extra cycle of an instruction in progress |
| done | output | 1 | Final cycle; updates commit at the next edge |
| x_q | output | DW | x register |
| y_q | output | DW | y register |
| p_q | output | 2*DW | Product register |
| a0_q | output | 2*DW+GUARD | Accumulator 0 |
| a1_q | output | 2*DW+GUARD | Accumulator 1 |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Guard-bit overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The assertions check on every cycle that registers move only after a `done` cycle and that `busy` continues until `done`. They also check that store strobes occur only in final cycles, that stores never finish in their first cycle, that an in-cache dual read with no clash or wait finishes at once, and that a lone multiply lands in p at the next edge. Only the bench's sweeps can show the arithmetic: each function with each transfer, both accumulators and both halves, with the keep bit set and cleared. The sweeps also cover the exact flag values, the exact cycle count under each mix of cache, clash and wait-states, and that instructions offered while busy are ignored.

// File: rtl/mac_alu_unit.sv
module mac_alu_unit #(
  parameter int DW    = 16,
  parameter int GUARD = 4,
  parameter int WSW   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue,
  input  logic [3:0]              func,
  input  logic [2:0]              xfer,
  input  logic                    dst_sel,
  input  logic                    src_sel,
  input  logic                    acc_t_sel,
  input  logic                    low_sel,
  input  logic                    in_cache,
  input  logic                    bank_hit,
  input  logic [WSW-1:0]          wait_states,
  input  logic                    cfg_we,
  input  logic                    cfg_keep_low,
  input  logic [DW-1:0]           xdata,
  input  logic [DW-1:0]           ydata,
  output logic                    mem_we,
  output logic [DW-1:0]           mem_wdata,
  output logic                    busy,
  output logic                    done,
  output logic [DW-1:0]           x_q,
  output logic [DW-1:0]           y_q,
  output logic [2*DW-1:0]         p_q,
  output logic [2*DW+GUARD-1:0]   a0_q,
  output logic [2*DW+GUARD-1:0]   a1_q,
  output logic                    flag_n,
  output logic                    flag_z,
  output logic                    flag_v,
  output logic                    flag_c
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GUARD;
  localparam int CW = WSW + 2;
  localparam int IW = 11;

  localparam logic [3:0] F_MPY = 4'd1, F_LDP = 4'd2, F_ADDP = 4'd3, F_SUBP = 4'd4,
                         F_LDY = 4'd5, F_ADDY = 4'd6, F_SUBY = 4'd7, F_AND = 4'd8,
                         F_OR = 4'd9, F_XOR = 4'd10, F_CMP = 4'd11, F_TST = 4'd12,
                         F_LDPM = 4'd13, F_ADDPM = 4'd14, F_SUBPM = 4'd15;
  localparam logic [2:0] T_DUAL = 3'd1, T_LDY = 3'd2, T_LDX = 3'd3, T_LDA = 3'd4,
                         T_STY = 3'd5, T_STA = 3'd6, T_MVY = 3'd7;

  logic [IW-1:0] ins_q, ins_live, ins;
  logic [CW-1:0] cnt_q, n_cyc;
  logic [1:0]    base;
  logic          busy_q, accept, last, keep_q;

  assign ins_live = {func, xfer, dst_sel, src_sel, acc_t_sel, low_sel};
  assign ins      = busy_q ? ins_q : ins_live;

  logic [3:0] f;
  logic [2:0] t;
  logic       dsel, ssel, tsel, lo;
  assign {f, t, dsel, ssel, tsel, lo} = ins;

  always_comb begin
    base = 2'd1;
    if (xfer == T_STY || xfer == T_STA) base = 2'd2;
    else if (xfer == T_DUAL && !in_cache) base = 2'd2;
  end

  assign n_cyc = CW'(base) + CW'(xfer == T_DUAL && bank_hit)
               + ((xfer != 3'd0 && xfer != T_MVY) ? CW'(wait_states) : CW'(0));

  assign accept = issue && !busy_q;
  assign last   = (accept && n_cyc == CW'(1)) || (busy_q && cnt_q == CW'(1));
  assign busy   = busy_q;
  assign done   = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ins_q  <= '0;
    end else if (accept) begin
      ins_q <= ins_live;
      if (n_cyc != CW'(1)) begin
        busy_q <= 1'b1;
        cnt_q  <= n_cyc - CW'(1);
      end
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  logic [AW-1:0] a_s, a_t, p_ext, y_ext, opnd, res;
  logic [AW:0]   sum;
  logic [DW-1:0] t_half;
  logic          do_sub, arith, wr_acc, upd_flags, mpy;

  assign a_s    = ssel ? a1_q : a0_q;
  assign a_t    = tsel ? a1_q : a0_q;
  assign p_ext  = {{GUARD{p_q[PW-1]}}, p_q};
  assign y_ext  = {{GUARD{y_q[DW-1]}}, y_q, {DW{1'b0}}};
  assign t_half = lo ? a_t[DW-1:0] : a_t[PW-1:DW];
  assign mpy    = (f == F_MPY) || (f == F_LDPM) || (f == F_ADDPM) || (f == F_SUBPM);
  assign sum    = {1'b0, a_s} + {1'b0, do_sub ? ~opnd : opnd} + {{AW{1'b0}}, do_sub};

  always_comb begin
    opnd      = p_ext;
    do_sub    = 1'b0;
    arith     = 1'b0;
    wr_acc    = 1'b1;
    upd_flags = 1'b1;
    res       = '0;
    case (f)
      F_LDP, F_LDPM:   res = p_ext;
      F_ADDP, F_ADDPM: arith = 1'b1;
      F_SUBP, F_SUBPM: begin arith = 1'b1; do_sub = 1'b1; end
      F_LDY:           res = y_ext;
      F_ADDY:          begin opnd = y_ext; arith = 1'b1; end
      F_SUBY:          begin opnd = y_ext; arith = 1'b1; do_sub = 1'b1; end
      F_CMP:           begin opnd = y_ext; arith = 1'b1; do_sub = 1'b1; wr_acc = 1'b0; end
      F_AND:           res = a_s & y_ext;
      F_TST:           begin res = a_s & y_ext; wr_acc = 1'b0; end
      F_OR:            res = a_s | y_ext;
      F_XOR:           res = a_s ^ y_ext;
      default:         begin wr_acc = 1'b0; upd_flags = 1'b0; end
    endcase
    if (arith) res = sum[AW-1:0];
  end

  logic [AW-1:0] a0_n, a1_n, ld_val;
  logic [DW-1:0] x_n, y_n;

  always_comb begin
    ld_val = lo ? {a_t[AW-1:DW], ydata}
                : {{GUARD{ydata[DW-1]}}, ydata, keep_q ? a_t[DW-1:0] : {DW{1'b0}}};
    a0_n = a0_q;
    a1_n = a1_q;
    if (wr_acc) begin
      if (dsel) a1_n = res;
      else      a0_n = res;
    end
    if (t == T_LDA) begin
      if (tsel) a1_n = ld_val;
      else      a0_n = ld_val;
    end
    x_n = (t == T_DUAL || t == T_LDX) ? xdata : x_q;
    y_n = y_q;
    if (t == T_DUAL || t == T_LDY) y_n = ydata;
    else if (t == T_MVY)           y_n = t_half;
  end

  assign mem_we    = last && (t == T_STY || t == T_STA);
  assign mem_wdata = (t == T_STA) ? t_half : y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a0_q   <= '0;
      a1_q   <= '0;
      p_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
      keep_q <= 1'b0;
    end else begin
      if (cfg_we) keep_q <= cfg_keep_low;
      if (last) begin
        a0_q <= a0_n;
        a1_q <= a1_n;
        x_q  <= x_n;
        y_q  <= y_n;
        if (mpy) p_q <= $signed(x_q) * $signed(y_q);
        if (upd_flags) begin
          flag_n <= res[AW-1];
          flag_z <= ~|res;
          flag_v <= ~(&res[AW-1:PW-1]) & (|res[AW-1:PW-1]);
          flag_c <= arith & sum[AW];
        end
      end
    end
  end
endmodule

module mac_alu_unit_chk #(
  parameter int DW    = 16,
  parameter int GUARD = 4,
  parameter int WSW   = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  issue,
  input logic [3:0]            func,
  input logic [2:0]            xfer,
  input logic                  in_cache,
  input logic                  bank_hit,
  input logic [WSW-1:0]        wait_states,
  input logic                  busy,
  input logic                  done,
  input logic                  mem_we,
  input logic [DW-1:0]         x_q,
  input logic [DW-1:0]         y_q,
  input logic [2*DW-1:0]       p_q,
  input logic [2*DW+GUARD-1:0] a0_q,
  input logic [2*DW+GUARD-1:0] a1_q
);
  a_r13_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (a0_q == '0 && a1_q == '0 && p_q == '0 && !busy));

  a_r7_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r6_store_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !busy && (xfer == 3'd5 || xfer == 3'd6)) |-> !done);

  a_r6_cached_dual_one: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !busy && xfer == 3'd1 && in_cache && !bank_hit && wait_states == '0) |-> done);

  a_r10_store_final: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> done);

  a_r11_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(a0_q) && $stable(a1_q) && $stable(p_q) && $stable(x_q) && $stable(y_q)));

  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !busy && func == 4'd1) |=> $signed(p_q) == $signed($past(x_q)) * $signed($past(y_q)));
endmodule

bind mac_alu_unit mac_alu_unit_chk #(.DW(DW), .GUARD(GUARD), .WSW(WSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .func(func), .xfer(xfer),
  .in_cache(in_cache), .bank_hit(bank_hit), .wait_states(wait_states),
  .busy(busy), .done(done), .mem_we(mem_we), .x_q(x_q), .y_q(y_q),
  .p_q(p_q), .a0_q(a0_q), .a1_q(a1_q)
);

// File: tb/mac_alu_unit_bench.sv
module mac_alu_unit_bench;
  localparam int DW = 16, GUARD = 4, WSW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, issue, dst_sel, src_sel, acc_t_sel, low_sel, in_cache, bank_hit;
  logic cfg_we, cfg_keep_low, mem_we, busy, done, flag_n, flag_z, flag_v, flag_c;
  logic [3:0] func;
  logic [2:0] xfer;
  logic [WSW-1:0] wait_states;
  logic [15:0] xdata, ydata, mem_wdata, x_q, y_q;
  logic [31:0] p_q;
  logic [35:0] a0_q, a1_q;

  mac_alu_unit #(.DW(DW), .GUARD(GUARD), .WSW(WSW)) u_mac_alu_unit (.*);

  int checks = 0, errors = 0;
  logic [35:0] ma0, ma1;
  logic [31:0] mp;
  logic [15:0] mx, my;
  logic mn, mz, mv, mc, mkeep;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] v = s;
    v = v ^ (v << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_keep(input logic v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_keep_low = v;
    @(negedge clk);
    cfg_we = 1'b0;
    mkeep = v;
  endtask

  task automatic exec(input logic [3:0] f, input logic [2:0] t, input logic d, input logic s,
                      input logic ts, input logic l, input logic cache, input logic hit,
                      input int ws, input logic [15:0] xd, input logic [15:0] yd);
    int n, k;
    bit busy_ok, we_ok, wr;
    logic [15:0] wexp, nx, ny;
    logic [35:0] as_v, at_v, pe, ye, r, na0, na1, ldv;
    logic [31:0] np;
    logic signed [31:0] prod;
    logic cc, wa, uf;
    string tag;

    n = ((t == 3'd5 || t == 3'd6) || (t == 3'd1 && !cache)) ? 2 : 1;
    if (t == 3'd1 && hit) n++;
    if (t != 3'd0 && t != 3'd7) n += ws;
    as_v = s ? ma1 : ma0;
    at_v = ts ? ma1 : ma0;
    wr = (t == 3'd5 || t == 3'd6);
    wexp = (t == 3'd6) ? (l ? at_v[15:0] : at_v[31:16]) : my;

    @(negedge clk);
    issue = 1'b1; func = f; xfer = t; dst_sel = d; src_sel = s; acc_t_sel = ts; low_sel = l;
    in_cache = cache; bank_hit = hit; wait_states = WSW'(ws); xdata = xd; ydata = yd;
    #1;
    k = 1; busy_ok = 1; we_ok = 1;
    while (1) begin
      if (busy !== (k > 1)) busy_ok = 0;
      if (done === 1'b1) break;
      if (mem_we !== 1'b0) we_ok = 0;
      if (k > 30) break;
      @(negedge clk);
      // R7: a second instruction offered while busy must be ignored
      func = ~f; xfer = 3'd5; dst_sel = ~d; src_sel = ~s;
      #1;
      k++;
    end
    chk("R6", "cycle count", 64'(k), 64'(n));
    checks++;
    if (!busy_ok) begin errors++; $display("FAIL R7 busy pattern: actual wrong expected high in cycles 2..%0d", n); end
    chk("R10", "store strobe", {62'd0, ~we_ok, mem_we}, {62'd0, 1'b0, wr});
    if (wr) chk("R10", "store data", 64'(mem_wdata), 64'(wexp));

    pe = {{4{mp[31]}}, mp};
    ye = {{4{my[15]}}, my, 16'h0};
    r = '0; cc = 1'b0;
    case (f)
      4'd2, 4'd13: r = pe;
      4'd3, 4'd14: begin r = as_v + pe; cc = (r < as_v); end
      4'd4, 4'd15: begin r = as_v - pe; cc = (as_v >= pe); end
      4'd5: r = ye;
      4'd6: begin r = as_v + ye; cc = (r < as_v); end
      4'd7, 4'd11: begin r = as_v - ye; cc = (as_v >= ye); end
      4'd8, 4'd12: r = as_v & ye;
      4'd9: r = as_v | ye;
      4'd10: r = as_v ^ ye;
      default: ;
    endcase
    wa = (f >= 4'd2 && f <= 4'd10) || f >= 4'd13;
    uf = (f >= 4'd2);
    prod = $signed(mx) * $signed(my);
    np = (f == 4'd1 || f >= 4'd13) ? prod : mp;
    na0 = ma0; na1 = ma1;
    if (wa) begin if (d) na1 = r; else na0 = r; end
    if (t == 3'd4) begin
      ldv = l ? {at_v[35:16], yd} : {{4{yd[15]}}, yd, (mkeep ? at_v[15:0] : 16'h0)};
      if (ts) na1 = ldv; else na0 = ldv;
    end
    nx = (t == 3'd1 || t == 3'd3) ? xd : mx;
    ny = (t == 3'd1 || t == 3'd2) ? yd : (t == 3'd7 ? (l ? at_v[15:0] : at_v[31:16]) : my);
    ma0 = na0; ma1 = na1; mp = np; mx = nx; my = ny;
    if (uf) begin
      mn = r[35]; mz = (r == 36'd0);
      mv = !(r[35:31] == 5'h1f || r[35:31] == 5'h00);
      mc = cc;
    end

    if (t == 3'd4) tag = l ? "R9" : "R8";
    else if (f == 4'd0 && t == 3'd0) tag = "R11";
    else if (f >= 4'd8 && f <= 4'd12) tag = "R4";
    else if (f >= 4'd5 && f <= 4'd7) tag = "R3";
    else tag = "R2";

    @(negedge clk);
    issue = 1'b0;
    #1;
    chk(tag, "a0", 64'(a0_q), 64'(ma0));
    chk(tag, "a1", 64'(a1_q), 64'(ma1));
    chk("R1", "p", 64'(p_q), 64'(mp));
    chk("R12", "x,y", {32'd0, x_q, y_q}, {32'd0, mx, my});
    chk("R5", "flags n,z,v,c", {60'd0, flag_n, flag_z, flag_v, flag_c}, {60'd0, mn, mz, mv, mc});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; issue = 1'b0; func = '0; xfer = '0; dst_sel = 0; src_sel = 0; acc_t_sel = 0;
    low_sel = 0; in_cache = 0; bank_hit = 0; wait_states = '0; cfg_we = 0; cfg_keep_low = 0;
    xdata = '0; ydata = '0;
    ma0 = '0; ma1 = '0; mp = '0; mx = '0; my = '0; mn = 0; mz = 0; mv = 0; mc = 0; mkeep = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R13 reset state
    chk("R13", "regs after reset", {28'd0, a0_q}, 64'd0);
    chk("R13", "a1,p after reset", {a1_q[31:0], p_q}, 64'd0);
    chk("R13", "x,y,flags,busy", {39'd0, x_q, y_q, flag_n, flag_z, flag_v, flag_c, busy}, 64'd0);

    // R11 nop on zero state, then seed operands
    exec(4'd0, 3'd0, 0, 0, 0, 0, 1, 0, 0, 16'h0, 16'h0);
    exec(4'd0, 3'd1, 0, 0, 0, 0, 1, 0, 0, 16'h7fff, 16'h8000);
    exec(4'd1, 3'd0, 0, 0, 0, 0, 1, 0, 0, 16'h0, 16'h0);

    // Sweep of function x transfer x selectors under both keep-bit settings (R1..R12)
    for (int kp = 0; kp < 2; kp++) begin
      set_keep(kp[0]);
      for (int f = 0; f < 16; f++)
        for (int t = 0; t < 8; t++)
          for (int sel = 0; sel < 4; sel++) begin
            rng = nxt(rng);
            exec(4'(f), 3'(t), sel[0], rng[20], sel[1], rng[21], rng[22], rng[23],
                 int'(rng[25:24]), rng[15:0], (rng[26] ? rng[31:16] : {rng[31], 15'h7ff0}));
          end
    end

    // R6 cycle sweep over cache, bank clash and wait-states
    for (int t = 0; t < 8; t++)
      for (int c = 0; c < 2; c++)
        for (int h = 0; h < 2; h++)
          for (int w = 0; w < 4; w++) begin
            rng = nxt(rng);
            exec(4'd0, 3'(t), 0, 0, rng[3], rng[4], c[0], h[0], w, rng[15:0], rng[31:16]);
          end

    // R12 transfer wins over function on the same accumulator
    exec(4'd6, 3'd4, 0, 0, 0, 0, 1, 0, 0, 16'h0, 16'h1234);
    // R5 overflow into guard bits via repeated accumulation
    exec(4'd0, 3'd1, 0, 0, 0, 0, 1, 0, 0, 16'h8000, 16'h8000);
    exec(4'd1, 3'd0, 0, 0, 0, 0, 1, 0, 0, 16'h0, 16'h0);
    exec(4'd2, 3'd0, 1, 1, 0, 0, 1, 0, 0, 16'h0, 16'h0);
    exec(4'd3, 3'd0, 1, 1, 0, 0, 1, 0, 0, 16'h0, 16'h0);
    exec(4'd11, 3'd0, 0, 1, 0, 0, 1, 0, 0, 16'h0, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule